// File: doc/BRIEF.md
# Password Verifier with Attempts Counters

This block decides whether a presented 24-bit password opens one of sixteen stored passwords: a read and a write password in each of eight sets. A start strobe comes with a 4-bit selector and the presented value. In the same cycle the surrounding logic supplies the stored password and that password's 8-bit attempts counter. One clock later the block returns the new counter value with a one-cycle write-back strobe. It also updates a single verified-password record, which is a valid flag plus the selector of the password that last passed.

The attempts counter is a thermometer of cleared bits. A fresh counter reads FF. Each failure clears one more bit, starting from the least significant end. A counter of 00 is exhausted, and a password behind an exhausted counter is never evaluated. Only one password can be verified at a time, and every new presentation withdraws the previous privilege before it is judged. The asynchronous reset withdraws all privilege.

Top module: `pw_verifier`

## Requirements
- R1: The selector is {r, set}: bit 3 set to 1 names the read password and bit 3 set to 0 names the write password, and bits 2:0 give the set. Selector 0111, the write password of set 7, is the secure code and is handled like any other entry. On a pass, grant_sel reports the presented selector.
- R2: A wrong password behind a counter that is not exhausted gives cnt_out equal to the stored counter shifted left by one with a 0 entering bit 0, so FF becomes FE and then FC.
- R3: A matching password behind a counter that is not exhausted gives cnt_out = FF and grant_valid = 1.
- R4: A stored counter of 00 blocks evaluation. Even a matching password leaves grant_valid = 0, and cnt_out = 00.
- R5: Any presentation that does not pass clears grant_valid, and grant_sel reads 0 while grant_valid is 0.
- R6: While rst_n is low, grant_valid, grant_sel, cnt_we and cnt_out are all 0.
- R7: Each start cycle produces exactly one cnt_we pulse on the following cycle. Starts on consecutive cycles each get their own pulse.
- R8: Without a start, grant_valid and grant_sel keep their values.
- R9: A matching password behind a partly used counter, such as FC, restores the counter to FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; withdraws all privilege |
| start | input | 1 | Presentation strobe, one cycle per attempt |
| sel | input | 4 | {read/write, set number} of the password tried |
| pw_in | input | 24 | Presented password |
| stored_pw | input | 24 | Stored password at sel, valid with start |
| stored_cnt | input | 8 | Stored attempts counter at sel, valid with start |
| cnt_out | output | 8 | Counter value to write back |
| cnt_we | output | 1 | One-cycle write-back strobe |
| grant_valid | output | 1 | A password is currently verified |
| grant_sel | output | 4 | Selector of the verified password, 0 when none |

## Verification
The assertions assume three things. First, stored_pw and stored_cnt belong to the selector presented in the same cycle. Second, every stored counter is a proper thermometer of the form ones followed by zeros. Third, a counter has been written back before its selector is presented again. The bench keeps to all three. It holds the sixteen passwords and counters in arrays indexed by the selector and starts every counter at FF. It writes cnt_out back as soon as cnt_we is seen, and it presents the same selector on two consecutive cycles only in the back-to-back case, where the two selectors differ.

// File: rtl/pw_verifier.sv
module pw_verifier #(
  parameter int PW_W     = 24,
  parameter int CNT_W    = 8,
  parameter int SET_BITS = 3,
  localparam int SEL_W   = SET_BITS + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEL_W-1:0] sel,
  input  logic [PW_W-1:0]  pw_in,
  input  logic [PW_W-1:0]  stored_pw,
  input  logic [CNT_W-1:0] stored_cnt,
  output logic [CNT_W-1:0] cnt_out,
  output logic             cnt_we,
  output logic             grant_valid,
  output logic [SEL_W-1:0] grant_sel
);

  logic             locked, match, pass;
  logic [CNT_W-1:0] next_cnt;

  assign locked   = (stored_cnt == '0);
  assign match    = (pw_in == stored_pw);
  assign pass     = !locked && match;
  assign next_cnt = locked ? '0 : (match ? '1 : {stored_cnt[CNT_W-2:0], 1'b0});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_out     <= '0;
      cnt_we      <= 1'b0;
      grant_valid <= 1'b0;
      grant_sel   <= '0;
    end else begin
      cnt_we <= start;
      if (start) begin
        cnt_out     <= next_cnt;
        grant_valid <= pass;
        grant_sel   <= pass ? sel : '0;
      end
    end
  end

  AST_PASS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_we && grant_valid) |-> (cnt_out == {CNT_W{1'b1}})); // R3

  AST_WRONG_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && stored_cnt != '0 && pw_in != stored_pw) |=>
      (cnt_out == {$past(stored_cnt[CNT_W-2:0]), 1'b0})); // R2

  AST_LOCK_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && stored_cnt == '0) |=> (!grant_valid && cnt_out == '0)); // R4

  AST_REVOKE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (stored_cnt == '0 || pw_in != stored_pw)) |=> !grant_valid); // R5

  AST_NO_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |-> (grant_sel == '0)); // R5

  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(grant_valid) && $stable(grant_sel))); // R8

  AST_GRANT_WITH_WB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> cnt_we); // R7

  AST_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |-> (((~cnt_out) & ((~cnt_out) + 1'b1)) == '0)); // R2

endmodule

// File: tb/tb_pw_verifier.sv
`timescale 1ns/1ps
module tb_pw_verifier;
  logic        clk = 0, rst_n = 0, start = 0;
  logic [3:0]  sel = 0;
  logic [23:0] pw_in = 0;
  logic [23:0] stored_pw;
  logic [7:0]  stored_cnt;
  logic [7:0]  cnt_out;
  logic        cnt_we, grant_valid;
  logic [3:0]  grant_sel;

  logic [23:0] pw_mem  [16];
  logic [7:0]  cnt_mem [16];
  assign stored_pw  = pw_mem[sel];
  assign stored_cnt = cnt_mem[sel];

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pw_verifier dut (.clk(clk), .rst_n(rst_n), .start(start), .sel(sel), .pw_in(pw_in),
    .stored_pw(stored_pw), .stored_cnt(stored_cnt), .cnt_out(cnt_out), .cnt_we(cnt_we),
    .grant_valid(grant_valid), .grant_sel(grant_sel));

  logic       e_we, e_gv;
  logic [7:0] e_cnt;
  logic [3:0] e_gs;
  int         wbq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_we = 0; e_gv = 0; e_cnt = 0; e_gs = 0; wbq.delete();
    end else begin
      e_we = start;
      if (start) begin
        wbq.push_back(int'(sel));
        if (stored_cnt == 8'h00) begin
          e_cnt = 8'h00; e_gv = 0; e_gs = 0;
        end else if (pw_in == stored_pw) begin
          e_cnt = 8'hFF; e_gv = 1; e_gs = sel;
        end else begin
          e_cnt = {stored_cnt[6:0], 1'b0}; e_gv = 0; e_gs = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    @(negedge clk);
    chk(cnt_we == e_we, {tag, " cnt_we"}, cnt_we, e_we);
    chk(grant_valid == e_gv, {tag, " grant_valid"}, grant_valid, e_gv);
    chk(grant_sel == e_gs, {tag, " grant_sel"}, grant_sel, e_gs);
    if (e_we || !rst_n) chk(cnt_out == e_cnt, {tag, " cnt_out"}, cnt_out, e_cnt);
    if (cnt_we && wbq.size() > 0) cnt_mem[wbq.pop_front()] = cnt_out;
  endtask

  task automatic present(input logic [3:0] s, input logic [23:0] p, input string tag);
    start = 1; sel = s; pw_in = p;
    tick(tag);
    start = 0;
    tick(tag);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      pw_mem[i]  = 24'h5A0000 ^ (i * 24'h010203);
      cnt_mem[i] = 8'hFF;
    end
    tick("R6 reset");
    chk(grant_valid == 0 && cnt_we == 0, "R6 reset outputs", grant_valid, 0);
    rst_n = 1;
    tick("R6 release");

    present(4'd3, pw_mem[3], "R3 pass");
    chk(grant_valid == 1 && grant_sel == 4'd3, "R1 grant_sel write set3", grant_sel, 3);
    chk(cnt_mem[3] == 8'hFF, "R3 counter FF", cnt_mem[3], 8'hFF);
    repeat (4) tick("R8 hold");
    chk(grant_valid == 1, "R8 grant kept", grant_valid, 1);

    present(4'd9, 24'h000001, "R2 wrong");
    chk(grant_valid == 0, "R5 revoked by wrong", grant_valid, 0);
    chk(cnt_mem[9] == 8'hFE, "R2 FE", cnt_mem[9], 8'hFE);
    present(4'd9, 24'h000002, "R2 wrong2");
    chk(cnt_mem[9] == 8'hFC, "R2 FC", cnt_mem[9], 8'hFC);
    present(4'd9, pw_mem[9], "R9 restore");
    chk(cnt_mem[9] == 8'hFF, "R9 FC to FF", cnt_mem[9], 8'hFF);
    chk(grant_sel == 4'd9, "R1 read set1 selector", grant_sel, 9);

    present(4'd7, pw_mem[7], "R1 secure code");
    chk(grant_valid == 1 && grant_sel == 4'd7, "R1 secure code grant", grant_sel, 7);

    for (int k = 0; k < 8; k++) present(4'd12, 24'hFFFFFF, "R2 exhaust");
    chk(cnt_mem[12] == 8'h00, "R4 exhausted", cnt_mem[12], 0);
    present(4'd12, pw_mem[12], "R4 locked");
    chk(grant_valid == 0, "R4 correct but locked", grant_valid, 0);
    chk(cnt_mem[12] == 8'h00, "R4 stays 00", cnt_mem[12], 0);

    start = 1; sel = 4'd1; pw_in = pw_mem[1];
    tick("R7 b2b first");
    sel = 4'd2; pw_in = 24'h123456;
    tick("R7 b2b second");
    start = 0;
    tick("R7 b2b tail");
    chk(cnt_mem[1] == 8'hFF && cnt_mem[2] == 8'hFE, "R7 both written", cnt_mem[2], 8'hFE);
    chk(grant_valid == 0, "R5 second revokes first", grant_valid, 0);

    present(4'd5, pw_mem[5], "R3 pass again");
    rst_n = 0;
    tick("R6 mid reset");
    chk(grant_valid == 0 && grant_sel == 0, "R6 privilege cleared", grant_valid, 0);
    rst_n = 1;
    repeat (2) tick("R6 after");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule